// File: doc/BRIEF.md
# Posted-CAS Data Window Scheduler

This block sits on the controller side of a double-data-rate memory interface. It tracks when data must move on the shared data bus after a command goes out. It accepts one command per clock on a small command port: activate, read or write, each tagged with a bank number. It also takes the configured additive latency, CAS latency and burst length. For every column command it accepts, it raises a read-capture window or a write-drive window at the cycle offset the latencies imply. Across each window it presents a beat counter. Two transfers happen per clock, so a burst of four occupies two clocks and a burst of eight occupies four.

The read latency is the additive latency plus the CAS latency. The additive latency lets column commands be posted early. The write latency is one clock shorter than the read latency. Each window is tracked in a slot pipeline indexed by latency, so commands issued back to back stay independent. The block checks the minimum activate-to-column spacing for every bank. It also checks that a new window does not overlap one already pending. A violation of either rule raises a flag for one cycle and drops the command. The latency settings are taken from the inputs only while no window is pending.

Top module: `posted_cas_sched`

## Requirements
- R1: While reset is high and in the first cycle after it, `rd_win`, `wr_win`, `cmd_err`, `bus_conflict` and `busy` are low and both beat outputs are 0.
- R2: `cmd_op` encodes 0 = none, 1 = activate, 2 = read, 3 = write. An accepted read issued in cycle k raises `rd_win` first in cycle k + AL + CL, where AL is `cfg_al` and CL is `cfg_cl` (legal range: CL from 2 to MAX_CL, AL up to MAX_AL).
- R3: An accepted write issued in cycle k raises `wr_win` first in cycle k + AL + CL - 1.
- R4: A window lasts 2 clocks when `cfg_bl8` is 0 (burst of 4) and 4 clocks when `cfg_bl8` is 1 (burst of 8).
- R5: During a window, the matching beat output counts 0, 1, ... one step per clock. Outside any window it is 0.
- R6: A read or write to a bank that has never been activated since reset, or that was activated fewer than TRCD cycles earlier, is dropped. No window follows it, and `cmd_err` is high for exactly the next cycle.
- R7: A column command issued exactly TRCD cycles after the activate of its bank is accepted.
- R8: A column command whose window would overlap any pending read or write window is dropped, and `bus_conflict` is high for exactly the next cycle. Windows already pending are unchanged. `rd_win` and `wr_win` are never high together.
- R9: With AL = 2, CL = 3 and bursts of 4, a read in cycle k followed by a write to the same bank in cycle k+3 gives a read window in cycles k+5..k+6 and a write window in cycles k+7..k+8, with no flag.
- R10: The latency and burst settings are sampled only while `busy` is low. A command issued while a window is pending uses the settings held from the last idle cycle. New settings take effect once the block is idle again.
- R11: Reads with bursts of 4 issued two cycles apart produce one continuous window whose beat output runs 0, 1, 0, 1, with no conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 2 | Command: 0 none, 1 activate, 2 read, 3 write |
| cmd_bank | input | $clog2(NUM_BANKS) | Bank targeted by the command |
| cfg_al | input | 3 | Additive latency in clocks |
| cfg_cl | input | 3 | CAS latency in clocks |
| cfg_bl8 | input | 1 | 0: burst of 4, 1: burst of 8 |
| rd_win | output | 1 | Read-capture window active |
| rd_beat | output | 2 | Clock index within the read window |
| wr_win | output | 1 | Write-drive window active |
| wr_beat | output | 2 | Clock index within the write window |
| cmd_err | output | 1 | Previous cycle's column command broke the activate spacing and was dropped |
| bus_conflict | output | 1 | Previous cycle's column command would have overlapped a pending window and was dropped |
| busy | output | 1 | At least one data window is pending |

## Verification
The assertions assume the configuration inputs stay in the legal range: CAS latency at least 2 and at most MAX_CL, additive latency at most MAX_AL. They also assume that no activate is presented while reset is high, which would otherwise make the spacing check look back at an activate the bank never saw. The stimulus holds the command port at none through reset. It changes the configuration only between commands and always to legal values, including the smallest latency pair (AL 0, CL 2) and the largest (AL 4, CL 6). Every column command targets a bank activated long enough before, unless the test is meant to provoke the spacing error.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    localparam int AL_W   = 3;
    localparam int CL_W   = 3;
    localparam int LAT_W  = 4;
    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_ACT = 2'd1,
        OP_RD  = 2'd2,
        OP_WR  = 2'd3
    } sched_op_e;

    typedef struct packed {
        logic [AL_W-1:0] al;
        logic [CL_W-1:0] cl;
        logic            bl8;
    } lat_cfg_t;

    typedef struct packed {
        logic              live;
        logic [BEAT_W-1:0] beat;
    } slot_t;

    function automatic logic [LAT_W-1:0] read_lat(input lat_cfg_t c);
        return LAT_W'(c.al) + LAT_W'(c.cl);
    endfunction

    function automatic logic [LAT_W-1:0] write_lat(input lat_cfg_t c);
        return read_lat(c) - LAT_W'(1);
    endfunction

    function automatic logic [2:0] burst_clks(input logic bl8);
        return bl8 ? 3'd4 : 3'd2;
    endfunction

endpackage

// File: rtl/pcs_bank_timer.sv
module pcs_bank_timer #(
    parameter int NUM_BANKS = 4,
    parameter int TRCD      = 3,
    parameter int BANK_W    = 2,
    parameter int CNT_W     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act,
    input  logic [BANK_W-1:0] act_bank,
    input  logic [BANK_W-1:0] col_bank,
    output logic              col_ok
);

    logic [CNT_W-1:0]     cnt_q [NUM_BANKS];
    logic [NUM_BANKS-1:0] open_q;
    logic [NUM_BANKS-1:0] ready;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q[b]  <= '0;
                open_q[b] <= 1'b0;
            end else if (act && act_bank == BANK_W'(b)) begin
                cnt_q[b]  <= CNT_W'(TRCD - 1);
                open_q[b] <= 1'b1;
            end else if (cnt_q[b] != '0) begin
                cnt_q[b]  <= cnt_q[b] - CNT_W'(1);
            end
        end
        assign ready[b] = open_q[b] && (cnt_q[b] == '0);
    end

    assign col_ok = ready[col_bank];

    if (TRCD >= 2) begin : g_chk
        AST_TRCD_GUARD: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst && act) && $past(act_bank) == col_bank) |-> !col_ok); // R6
    end

endmodule

// File: rtl/pcs_window_pipe.sv
module pcs_window_pipe
    import pcs_pkg::*;
#(
    parameter int DEPTH = 14,
    parameter int OFF_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic [OFF_W-1:0] ld_off,
    input  logic [2:0]       ld_len,
    output slot_t            head,
    output logic [DEPTH-1:0] occ_sh,
    output logic             busy
);

    slot_t            slots_q [DEPTH];
    slot_t            sh      [DEPTH];
    slot_t            nxt     [DEPTH];
    logic [DEPTH-1:0] live_q;
    logic [DEPTH-1:0] hit;
    logic [DEPTH-1:0] clob;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        localparam logic [OFF_W:0] IDX = (OFF_W+1)'(i);
        if (i == DEPTH - 1) begin : g_tail
            assign sh[i] = '0;
        end else begin : g_mid
            assign sh[i] = slots_q[i+1];
        end
        assign hit[i] = ld && ({1'b0, ld_off} <= IDX)
                           && (IDX < {1'b0, ld_off} + (OFF_W+1)'(ld_len));
        always_comb begin
            nxt[i] = sh[i];
            if (hit[i]) begin
                nxt[i].live = 1'b1;
                nxt[i].beat = BEAT_W'(IDX - {1'b0, ld_off});
            end
        end
        assign occ_sh[i] = sh[i].live;
        assign live_q[i] = slots_q[i].live;
        assign clob[i]   = hit[i] && sh[i].live;
    end

    always_ff @(posedge clk) begin
        for (int j = 0; j < DEPTH; j++) begin
            if (rst) slots_q[j] <= '0;
            else     slots_q[j] <= nxt[j];
        end
    end

    assign head = slots_q[0];
    assign busy = |live_q;

    AST_NO_CLOBBER: assert property (@(posedge clk) disable iff (rst)
        clob == '0); // R8

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
        (head.live && head.beat != '0) |->
            ($past(head.live) && $past(head.beat) == head.beat - BEAT_W'(1))); // R5

endmodule

// File: rtl/posted_cas_sched.sv
module posted_cas_sched
    import pcs_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int TRCD      = 3,
    parameter int MAX_AL    = 4,
    parameter int MAX_CL    = 6,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int DEPTH    = MAX_AL + MAX_CL + 4,
    localparam int OFF_W    = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(TRCD + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmd_op,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [2:0]        cfg_al,
    input  logic [2:0]        cfg_cl,
    input  logic              cfg_bl8,
    output logic              rd_win,
    output logic [1:0]        rd_beat,
    output logic              wr_win,
    output logic [1:0]        wr_beat,
    output logic              cmd_err,
    output logic              bus_conflict,
    output logic              busy
);

    sched_op_e        op;
    lat_cfg_t         cfg_live, cfg_q, cfg_eff;
    logic             is_col, col_ok, overlap;
    logic [LAT_W-1:0] lat;
    logic [OFF_W-1:0] off;
    logic [2:0]       len;
    logic [DEPTH-1:0] mask;
    logic             err_q, conf_q;

    slot_t            head   [2];
    logic [DEPTH-1:0] occ_sh [2];
    logic [1:0]       pbusy;
    logic [1:0]       ld;

    function automatic logic [DEPTH-1:0] win_mask(input logic [OFF_W-1:0] o,
                                                  input logic [2:0] n);
        logic [DEPTH-1:0] m;
        for (int i = 0; i < DEPTH; i++) begin
            m[i] = (i >= int'(o)) && (i < int'(o) + int'(n));
        end
        return m;
    endfunction

    assign op       = sched_op_e'(cmd_op);
    assign is_col   = (op == OP_RD) || (op == OP_WR);
    assign cfg_live = '{al: cfg_al, cl: cfg_cl, bl8: cfg_bl8};
    assign busy     = |pbusy;
    assign cfg_eff  = busy ? cfg_q : cfg_live;

    always_comb begin
        lat = (op == OP_WR) ? write_lat(cfg_eff) : read_lat(cfg_eff);
        off = OFF_W'(lat - LAT_W'(1));
        len = burst_clks(cfg_eff.bl8);
    end

    assign mask    = win_mask(off, len);
    assign overlap = |(mask & (occ_sh[0] | occ_sh[1]));
    assign ld[0]   = (op == OP_RD) && col_ok && !overlap;
    assign ld[1]   = (op == OP_WR) && col_ok && !overlap;

    pcs_bank_timer #(
        .NUM_BANKS (NUM_BANKS),
        .TRCD      (TRCD),
        .BANK_W    (BANK_W),
        .CNT_W     (CNT_W)
    ) i_timer (
        .clk      (clk),
        .rst      (rst),
        .act      (op == OP_ACT),
        .act_bank (cmd_bank),
        .col_bank (cmd_bank),
        .col_ok   (col_ok)
    );

    for (genvar g = 0; g < 2; g++) begin : g_pipe
        pcs_window_pipe #(
            .DEPTH (DEPTH),
            .OFF_W (OFF_W)
        ) i_pipe (
            .clk    (clk),
            .rst    (rst),
            .ld     (ld[g]),
            .ld_off (off),
            .ld_len (len),
            .head   (head[g]),
            .occ_sh (occ_sh[g]),
            .busy   (pbusy[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '{al: '0, cl: CL_W'(3), bl8: 1'b0};
            err_q  <= 1'b0;
            conf_q <= 1'b0;
        end else begin
            if (!busy) cfg_q <= cfg_live;
            err_q  <= is_col && !col_ok;
            conf_q <= is_col && col_ok && overlap;
        end
    end

    assign rd_win       = head[0].live;
    assign rd_beat      = head[0].beat;
    assign wr_win       = head[1].live;
    assign wr_beat      = head[1].beat;
    assign cmd_err      = err_q;
    assign bus_conflict = conf_q;

    AST_BUS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rd_win && wr_win)); // R8

    AST_CFG_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (cfg_cl >= 3'd2) && (int'(cfg_cl) <= MAX_CL) && (int'(cfg_al) <= MAX_AL)); // R2

    AST_RD_LAST_BEAT: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_win) |-> ($past(rd_beat) == (cfg_q.bl8 ? 2'd3 : 2'd1))); // R4

    AST_WR_LAST_BEAT: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_win) |-> ($past(wr_beat) == (cfg_q.bl8 ? 2'd3 : 2'd1))); // R4

endmodule

// File: tb/test_posted_cas_sched.sv
module test_posted_cas_sched;

    localparam int LOGN = 2048;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] op  = 2'd0;
    logic [1:0] bank = 2'd0;
    logic [2:0] al = 3'd0;
    logic [2:0] cl = 3'd3;
    logic       bl8 = 1'b0;
    logic       rd_win, wr_win, cmd_err, bus_conflict, busy;
    logic [1:0] rd_beat, wr_beat;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    logic [7:0] lg  [LOGN];
    logic [7:0] ex  [LOGN];

    typedef struct packed {
        logic [2:0] al;
        logic [2:0] cl;
        logic       bl8;
        logic       wr;
        logic [4:0] st;
        logic [2:0] ln;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{3'd0, 3'd3, 1'b0, 1'b0, 5'd3,  3'd2},
        '{3'd0, 3'd3, 1'b0, 1'b1, 5'd2,  3'd2},
        '{3'd2, 3'd3, 1'b0, 1'b0, 5'd5,  3'd2},
        '{3'd2, 3'd3, 1'b0, 1'b1, 5'd4,  3'd2},
        '{3'd0, 3'd3, 1'b1, 1'b0, 5'd3,  3'd4},
        '{3'd2, 3'd3, 1'b1, 1'b1, 5'd4,  3'd4},
        '{3'd1, 3'd4, 1'b1, 1'b0, 5'd5,  3'd4},
        '{3'd0, 3'd2, 1'b0, 1'b1, 5'd1,  3'd2},
        '{3'd4, 3'd6, 1'b1, 1'b0, 5'd10, 3'd4},
        '{3'd3, 3'd5, 1'b0, 1'b1, 5'd7,  3'd2}
    };

    posted_cas_sched i_posted_cas_sched (
        .clk          (clk),
        .rst          (rst),
        .cmd_op       (op),
        .cmd_bank     (bank),
        .cfg_al       (al),
        .cfg_cl       (cl),
        .cfg_bl8      (bl8),
        .rd_win       (rd_win),
        .rd_beat      (rd_beat),
        .wr_win       (wr_win),
        .wr_beat      (wr_beat),
        .cmd_err      (cmd_err),
        .bus_conflict (bus_conflict),
        .busy         (busy)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // packed sample: {rd_win, rd_beat, wr_win, wr_beat, cmd_err, bus_conflict}
    always @(negedge clk) begin
        if (cyc < LOGN) lg[cyc] = {rd_win, rd_beat, wr_win, wr_beat, cmd_err, bus_conflict};
    end

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic drive(input logic [1:0] o, input logic [1:0] b, output int k);
        @(posedge clk);
        #1;
        op   = o;
        bank = b;
        k    = cyc;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            op = 2'd0;
        end
    endtask

    task automatic exp_win(input bit is_rd, input int k, input int st, input int ln);
        for (int i = 0; i < ln; i++) begin
            if (is_rd) ex[k+st+i][7:5] = {1'b1, 2'(i)};
            else       ex[k+st+i][4:2] = {1'b1, 2'(i)};
        end
    endtask

    task automatic cmp(input int from, input int to, input string tag);
        for (int c = from; c <= to; c++) begin
            check(lg[c] === ex[c], $sformatf("%s cycle=%0d", tag, c), int'(lg[c]), int'(ex[c]));
        end
    endtask

    initial begin
        int k, k2, a;
        for (int c = 0; c < LOGN; c++) ex[c] = 8'h00;

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check({rd_win, wr_win, cmd_err, bus_conflict, busy, rd_beat, wr_beat} === 9'd0,
              "R1 during reset", int'({rd_win, wr_win, cmd_err, bus_conflict, busy}), 0);
        rst = 1'b0;
        @(negedge clk);
        check({rd_win, wr_win, cmd_err, bus_conflict, busy, rd_beat, wr_beat} === 9'd0,
              "R1 after reset", int'({rd_win, wr_win, cmd_err, bus_conflict, busy}), 0);

        drive(2'd1, 2'd0, a);
        drive(2'd1, 2'd1, a);
        drive(2'd1, 2'd2, a);
        idle(6);

        // R2/R3/R4/R5: latency table
        for (int v = 0; v < 10; v++) begin
            @(posedge clk);
            #1;
            al  = VEC[v].al;
            cl  = VEC[v].cl;
            bl8 = VEC[v].bl8;
            drive(VEC[v].wr ? 2'd3 : 2'd2, 2'd0, k);
            idle(1);
            exp_win(!VEC[v].wr, k, int'(VEC[v].st), int'(VEC[v].ln));
            idle(int'(VEC[v].st) + int'(VEC[v].ln) + 4);
            cmp(k, k + int'(VEC[v].st) + int'(VEC[v].ln) + 2,
                VEC[v].wr ? "R3 R4 R5 write vector" : "R2 R4 R5 read vector");
        end

        al = 3'd0; cl = 3'd3; bl8 = 1'b0;

        // R6: column one cycle after activate
        drive(2'd1, 2'd1, a);
        drive(2'd2, 2'd1, k);
        idle(1);
        ex[k+1][1] = 1'b1;
        idle(12);
        cmp(a, k + 10, "R6 early read");

        // R6: column at TRCD-1 after activate
        drive(2'd1, 2'd0, a);
        idle(1);
        drive(2'd3, 2'd0, k);
        idle(1);
        ex[k+1][1] = 1'b1;
        idle(12);
        cmp(a, k + 10, "R6 write at TRCD-1");

        // R6: bank never activated
        drive(2'd2, 2'd3, k);
        idle(1);
        ex[k+1][1] = 1'b1;
        idle(12);
        cmp(k, k + 10, "R6 bank never opened");

        // R7: column exactly TRCD cycles later
        drive(2'd1, 2'd2, a);
        idle(2);
        drive(2'd2, 2'd2, k);
        idle(1);
        exp_win(1'b1, k, 3, 2);
        idle(10);
        cmp(a, k + 8, "R7 read at TRCD");

        // R8: read overlapping a pending read
        bl8 = 1'b1;
        drive(2'd2, 2'd0, k);
        drive(2'd2, 2'd0, k2);
        idle(1);
        exp_win(1'b1, k, 3, 4);
        ex[k2+1][0] = 1'b1;
        idle(12);
        cmp(k, k + 10, "R8 read over read");

        // R8: write overlapping a pending read
        bl8 = 1'b0;
        drive(2'd2, 2'd0, k);
        drive(2'd3, 2'd0, k2);
        idle(1);
        exp_win(1'b1, k, 3, 2);
        ex[k2+1][0] = 1'b1;
        idle(12);
        cmp(k, k + 10, "R8 write over read");

        // R11: seamless back-to-back reads
        drive(2'd2, 2'd0, k);
        idle(1);
        drive(2'd2, 2'd0, k2);
        idle(1);
        exp_win(1'b1, k, 3, 2);
        exp_win(1'b1, k2, 3, 2);
        idle(12);
        cmp(k, k + 10, "R11 seamless reads");

        // R9: read then write to the same bank, AL=2 CL=3
        @(posedge clk);
        #1;
        al = 3'd2;
        drive(2'd2, 2'd0, k);
        idle(2);
        drive(2'd3, 2'd0, k2);
        idle(1);
        exp_win(1'b1, k, 5, 2);
        exp_win(1'b0, k2, 4, 2);
        idle(14);
        cmp(k, k + 12, "R9 read then write");

        // R10: config change while busy is ignored until idle
        @(posedge clk);
        #1;
        al = 3'd0;
        drive(2'd2, 2'd0, k);
        @(posedge clk);
        #1;
        op = 2'd0;
        al = 3'd2;
        drive(2'd2, 2'd0, k2);
        idle(1);
        exp_win(1'b1, k, 3, 2);
        exp_win(1'b1, k2, 3, 2);
        idle(14);
        cmp(k, k + 12, "R10 held config");

        drive(2'd2, 2'd0, k);
        idle(1);
        exp_win(1'b1, k, 5, 2);
        idle(12);
        cmp(k, k + 10, "R10 new config after idle");

        summary();
        $finish;
    end

endmodule